// File: doc/BRIEF.md
# Passive FPGA Configuration Loader

This block drives the passive configuration pins of a downstream FPGA from a byte stream. A start pulse selects one of three loading modes and gives the total number of bytes. The loader then pulses the configuration-reset line low and waits a settle interval. It moves every byte out on a configuration clock and data bus that it generates itself, and at the end it checks the target's done indication. Every delay is derived from the system clock frequency, so the same engine suits any clock rate.

Three modes share one engine. Serial mode sends one bit per configuration clock, least significant bit first, on bit 0 of the bus. Parallel mode sends the whole byte with a single clock pulse. Secure parallel mode holds the byte for four clock pulses. Before each byte the loader samples the target's status input and stops with an error if the target has reported a fault. Bytes are taken from a valid/ready stream, and only when the engine is ready for the next one.

Top module: `cfg_loader`

## Requirements
- R1: After reset the loader is idle: `cfg_rst_n_o`=1, `cfg_clk_o`=0, `cfg_data_o`=0, `busy_o`, `in_ready_o`, `ok_o` and `err_o` are 0, and `sent_o`=0.
- R2: An accepted start drives `cfg_rst_n_o` low for exactly CLK_MHZ*RST_LOW_US cycles, beginning in the cycle after start is sampled. The line then stays high for CLK_MHZ*RST_WAIT_US cycles before the first configuration clock phase. The clock stays low and the data bus stays zero throughout.
- R3: The data bus changes only in cycles where the configuration clock is low. Each clock low phase and each high phase lasts HALF_CYC cycles.
- R4: With `mode_i`=0 (serial), every byte gives eight clock pulses. Pulse k carries bit k of the byte on `cfg_data_o[0]`, and the other bus bits are zero.
- R5: With `mode_i`=1 (parallel), every byte gives one clock pulse with the full byte on `cfg_data_o`.
- R6: With `mode_i`=2 (secure parallel), every byte gives four clock pulses and the byte stays on the bus for all four.
- R7: `status_i` is sampled in the single cycle before each byte is fetched. If it is low, the loader returns to idle with `err_o`=1, the pins are idle, and `sent_o` equals the number of bytes accepted so far.
- R8: After the last byte and one more status cycle, the clock is driven high and held for CLK_MHZ*DONE_WAIT_US cycles. `done_i` is then sampled: high sets `ok_o` and low sets `err_o`. In the next cycle the loader is idle with the clock low.
- R9: A start with `total_i`=0 or `mode_i`=3 sets `err_o` in the next cycle without leaving idle, and no configuration pin moves.
- R10: `in_ready_o` is high only while the loader waits for a byte, which is one cycle after each status check. It stays high until `in_valid_i` is seen, and a byte is taken only in a cycle where both are high.
- R11: A start pulse while `busy_o` is high has no effect. `ok_o` and `err_o` hold their values in idle until the next accepted start, which clears them in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a load (one-cycle pulse) |
| mode_i | input | 2 | 0 serial, 1 parallel, 2 secure parallel, 3 invalid |
| total_i | input | CNT_W | Number of bytes in the load |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Loader accepts a byte this cycle |
| status_i | input | 1 | Target status, high when healthy |
| done_i | input | 1 | Target configuration done |
| cfg_rst_n_o | output | 1 | Configuration-reset line to target, active low |
| cfg_clk_o | output | 1 | Configuration clock to target |
| cfg_data_o | output | 8 | Configuration data bus to target |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load completed with done high |
| err_o | output | 1 | Last load rejected, aborted or missing done |
| sent_o | output | CNT_W | Bytes accepted in the current or last load |

## Verification
The bench builds the loader with CLK_MHZ=1 and microsecond settings of 3, 4 and 5, a HALF_CYC of 2 and CNT_W=8. The reset pulse, the settle wait and the done wait therefore last a few cycles each, short enough that every clock phase of multi-byte loads in all three modes can be compared cycle by cycle against a behavioural model. These settings also allow status faults at the first and at a middle byte, stream stalls of several cycles, a missing done, invalid starts, and a start issued during the settle wait to be run in one short simulation.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_SER = 2'd0,
        MODE_PAR = 2'd1,
        MODE_SEC = 2'd2,
        MODE_BAD = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_CHECK,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_TAIL
    } state_e;

    typedef struct packed {
        logic              rst_n;
        logic              clk;
        logic [BYTE_W-1:0] data;
        logic              busy;
    } pins_t;

    // index of the final clock pulse of one byte in each mode
    function automatic logic [2:0] last_pulse(mode_e m);
        case (m)
            MODE_SER: return 3'd7;
            MODE_SEC: return 3'd3;
            default:  return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_pulse_timer.sv
module cfg_pulse_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_pin_fmt.sv
module cfg_pin_fmt
    import cfg_loader_pkg::*;
(
    input  state_e            st_i,
    input  mode_e             mode_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [2:0]        idx_i,
    output pins_t             pins_o
);
    logic [BYTE_W-1:0] shown;

    always_comb begin
        if (mode_i == MODE_SER)
            shown = {{(BYTE_W-1){1'b0}}, byte_i[idx_i]};
        else
            shown = byte_i;

        pins_o.rst_n = (st_i != ST_RST_LOW);
        pins_o.clk   = (st_i == ST_HIGH) || (st_i == ST_TAIL);
        pins_o.data  = ((st_i == ST_LOW) || (st_i == ST_HIGH)) ? shown : '0;
        pins_o.busy  = (st_i != ST_IDLE);
    end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter int RST_LOW_US   = 5,
    parameter int RST_WAIT_US  = 100,
    parameter int DONE_WAIT_US = 100,
    parameter int HALF_CYC     = 2,
    parameter int CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic             in_valid_i,
    input  logic [7:0]       in_data_i,
    output logic             in_ready_o,
    input  logic             status_i,
    input  logic             done_i,
    output logic             cfg_rst_n_o,
    output logic             cfg_clk_o,
    output logic [7:0]       cfg_data_o,
    output logic             busy_o,
    output logic             ok_o,
    output logic             err_o,
    output logic [CNT_W-1:0] sent_o
);
    localparam int RL_CYC = CLK_MHZ * RST_LOW_US;
    localparam int RW_CYC = CLK_MHZ * RST_WAIT_US;
    localparam int DW_CYC = CLK_MHZ * DONE_WAIT_US;
    localparam int MAX_A  = (RL_CYC > RW_CYC) ? RL_CYC : RW_CYC;
    localparam int MAX_B  = (DW_CYC > HALF_CYC) ? DW_CYC : HALF_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        state_e            st;
        mode_e             mode;
        logic [CNT_W-1:0]  total;
        logic [CNT_W-1:0]  sent;
        logic [BYTE_W-1:0] byte_v;
        logic [2:0]        idx;
        logic              ok;
        logic              err;
    } core_t;

    core_t core_d, core_q;
    pins_t pins_d, pins_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;

    cfg_pulse_timer #(.W(TMR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_done)
    );

    always_comb begin
        core_d   = core_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (core_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    core_d.ok    = 1'b0;
                    core_d.err   = 1'b0;
                    core_d.sent  = '0;
                    core_d.mode  = mode_e'(mode_i);
                    core_d.total = total_i;
                    if (total_i == '0 || mode_i == MODE_BAD) begin
                        core_d.err = 1'b1;
                    end else begin
                        core_d.st = ST_RST_LOW;
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(RL_CYC - 1);
                    end
                end
            end
            ST_RST_LOW: begin
                if (tmr_done) begin
                    core_d.st = ST_RST_WAIT;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(RW_CYC - 1);
                end
            end
            ST_RST_WAIT: begin
                if (tmr_done) core_d.st = ST_CHECK;
            end
            ST_CHECK: begin
                if (core_q.sent == core_q.total) begin
                    core_d.st = ST_TAIL;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(DW_CYC - 1);
                end else if (!status_i) begin
                    core_d.err = 1'b1;
                    core_d.st  = ST_IDLE;
                end else begin
                    core_d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (in_valid_i) begin
                    core_d.byte_v = in_data_i;
                    core_d.idx    = 3'd0;
                    core_d.sent   = core_q.sent + 1'b1;
                    core_d.st     = ST_LOW;
                    tmr_load      = 1'b1;
                    tmr_val       = TMR_W'(HALF_CYC - 1);
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    core_d.st = ST_HIGH;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(HALF_CYC - 1);
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    if (core_q.idx == last_pulse(core_q.mode)) begin
                        core_d.st = ST_CHECK;
                    end else begin
                        core_d.idx = core_q.idx + 3'd1;
                        core_d.st  = ST_LOW;
                        tmr_load   = 1'b1;
                        tmr_val    = TMR_W'(HALF_CYC - 1);
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_done) begin
                    if (done_i) core_d.ok  = 1'b1;
                    else        core_d.err = 1'b1;
                    core_d.st = ST_IDLE;
                end
            end
            default: core_d.st = ST_IDLE;
        endcase
    end

    cfg_pin_fmt u_fmt (
        .st_i   (core_d.st),
        .mode_i (core_d.mode),
        .byte_i (core_d.byte_v),
        .idx_i  (core_d.idx),
        .pins_o (pins_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
            pins_q <= '{rst_n: 1'b1, clk: 1'b0, data: '0, busy: 1'b0};
        end else begin
            core_q <= core_d;
            pins_q <= pins_d;
        end
    end

    assign in_ready_o  = (core_q.st == ST_FETCH);
    assign cfg_rst_n_o = pins_q.rst_n;
    assign cfg_clk_o   = pins_q.clk;
    assign cfg_data_o  = pins_q.data;
    assign busy_o      = pins_q.busy;
    assign ok_o        = core_q.ok;
    assign err_o       = core_q.err;
    assign sent_o      = core_q.sent;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       in_ready_o,
    input logic       cfg_rst_n_o,
    input logic       cfg_clk_o,
    input logic [7:0] cfg_data_o,
    input logic       busy_o,
    input logic       ok_o,
    input logic       err_o
);
    // R1: an idle loader leaves every target pin at rest
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cfg_rst_n_o && !cfg_clk_o && cfg_data_o == 8'h00));

    // R2: while the target is held in reset no clock or data moves
    a_r2_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_n_o |-> (busy_o && !cfg_clk_o && cfg_data_o == 8'h00));

    // R3: the bus only changes while the clock is low
    a_r3_data_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_data_o) |-> !cfg_clk_o);

    // R10: the stream is only taken mid-load with the clock low
    a_r10_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (busy_o && cfg_rst_n_o && !cfg_clk_o));

    // R8: success and error are never reported together
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && err_o));

    // R8: success only appears at the end of a load
    a_r8_ok_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> $past(busy_o));

    // R11: idle without a start keeps the result flags
    a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(ok_o) && $stable(err_o)));
endmodule

bind cfg_loader cfg_loader_chk u_chk (.*);

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
    localparam int PERIOD   = 10;
    localparam int CLK_MHZ  = 1;
    localparam int RL       = CLK_MHZ * 3;
    localparam int RW       = CLK_MHZ * 4;
    localparam int DW       = CLK_MHZ * 5;
    localparam int H        = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [7:0] total_i = 8'd0;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_data_i = 8'd0;
    logic       in_ready_o;
    logic       status_i = 1'b1;
    logic       done_i = 1'b1;
    logic       cfg_rst_n_o, cfg_clk_o, busy_o, ok_o, err_o;
    logic [7:0] cfg_data_o;
    logic [7:0] sent_o;

    cfg_loader #(
        .CLK_MHZ(CLK_MHZ), .RST_LOW_US(3), .RST_WAIT_US(4),
        .DONE_WAIT_US(5), .HALF_CYC(H), .CNT_W(8)
    ) uut (.*);

    always #(PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // expected port values, updated right after each rising edge
    bit       e_rstn = 1, e_clk = 0, e_busy = 0, e_ready = 0, e_ok = 0, e_err = 0;
    bit [7:0] e_data = 0;
    int       e_sent = 0;
    bit       m_ok = 0, m_err = 0;
    int       m_sent = 0;
    string    cur_req = "R1";
    bit       cmp_on = 0;
    logic [7:0] bytes[$];

    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (cfg_rst_n_o !== e_rstn || cfg_clk_o !== e_clk || cfg_data_o !== e_data ||
                busy_o !== e_busy || in_ready_o !== e_ready || ok_o !== e_ok ||
                err_o !== e_err || sent_o !== 8'(e_sent)) begin
                errors++;
                $display("FAIL %s t=%0t: got rst_n=%b clk=%b data=%h busy=%b ready=%b ok=%b err=%b sent=%0d expected rst_n=%b clk=%b data=%h busy=%b ready=%b ok=%b err=%b sent=%0d",
                    cur_req, $time, cfg_rst_n_o, cfg_clk_o, cfg_data_o, busy_o, in_ready_o,
                    ok_o, err_o, sent_o, e_rstn, e_clk, e_data, e_busy, e_ready, e_ok, e_err, e_sent);
            end
        end
    end

    task automatic check_val(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n, bit rn, bit ck, bit [7:0] d, bit bz, bit rd, string req);
        repeat (n) begin
            @(posedge clk);
            e_rstn = rn; e_clk = ck; e_data = d; e_busy = bz; e_ready = rd;
            e_ok = m_ok; e_err = m_err; e_sent = m_sent; cur_req = req;
        end
    endtask

    task automatic model(int mode, int gap, int fail_at, bit done_v);
        int n = bytes.size();
        int np;
        bit [7:0] d;
        m_ok = 0; m_err = 0; m_sent = 0;
        if (n == 0 || mode == 3) begin
            m_err = 1;
            cyc(1, 1, 0, 0, 0, 0, "R9");
            return;
        end
        np = (mode == 0) ? 8 : (mode == 2) ? 4 : 1;
        cyc(RL, 0, 0, 0, 1, 0, "R2");
        cyc(RW, 1, 0, 0, 1, 0, "R2");
        for (int b = 0; b < n; b++) begin
            cyc(1, 1, 0, 0, 1, 0, "R7");
            if (b == fail_at) begin
                m_err = 1;
                cyc(1, 1, 0, 0, 0, 0, "R7");
                return;
            end
            cyc(gap + 1, 1, 0, 0, 1, 1, "R10");
            m_sent++;
            for (int p = 0; p < np; p++) begin
                d = (mode == 0) ? {7'b0, bytes[b][p]} : bytes[b];
                cyc(H, 1, 0, d, 1, 0, (mode == 0) ? "R4" : (mode == 1) ? "R5" : "R6");
                cyc(H, 1, 1, d, 1, 0, "R3");
            end
        end
        cyc(1, 1, 0, 0, 1, 0, "R8");
        cyc(DW, 1, 1, 0, 1, 0, "R8");
        if (done_v) m_ok = 1; else m_err = 1;
        cyc(1, 1, 0, 0, 0, 0, "R8");
    endtask

    task automatic feed(int mode, int gap, int fail_at);
        int n = bytes.size();
        int limit = (fail_at >= 0 && fail_at < n) ? fail_at : n;
        if (mode == 3) limit = 0;
        for (int k = 0; k < limit; k++) begin
            do begin @(posedge clk); #1; end while (!in_ready_o);
            repeat (gap) begin @(posedge clk); #1; end
            in_valid_i = 1'b1;
            in_data_i  = bytes[k];
            @(posedge clk); #1;
            in_valid_i = 1'b0;
            if (k + 1 == fail_at) status_i = 1'b0;
        end
    endtask

    task automatic run_load(int mode, int gap, int fail_at, bit done_v, bit poke);
        @(posedge clk); #1;
        status_i = (fail_at == 0) ? 1'b0 : 1'b1;
        done_i   = done_v;
        mode_i   = 2'(mode);
        total_i  = 8'(bytes.size());
        start_i  = 1'b1;
        fork
            model(mode, gap, fail_at, done_v);
            begin
                @(posedge clk); #1;
                start_i = 1'b0;
                feed(mode, gap, fail_at);
            end
            begin
                if (poke) begin
                    repeat (RL + 1) @(posedge clk);
                    #1;
                    start_i = 1'b1; mode_i = 2'd3; total_i = 8'd0;
                    @(posedge clk); #1;
                    start_i = 1'b0;
                end
            end
        join
        repeat (3) @(posedge clk);
        status_i = 1'b1;
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 cmp_on = 1;          // R1: reset values compared while reset is held
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        check_val("R1", "sent after reset", int'(sent_o), 0);

        // R4: serial, two bytes, no stall, done high
        bytes = '{8'hA5, 8'h3C};
        run_load(0, 0, -1, 1'b1, 1'b0);
        check_val("R4", "ok after serial load", int'(ok_o), 1);

        // R5 / R10: parallel, three bytes, stream stalls two cycles
        bytes = '{8'h81, 8'h7E, 8'hC3};
        run_load(1, 2, -1, 1'b1, 1'b0);
        check_val("R5", "sent after parallel load", int'(sent_o), 3);

        // R6 / R8: secure parallel, done stays low
        bytes = '{8'h5A, 8'hF0};
        run_load(2, 1, -1, 1'b0, 1'b0);
        check_val("R8", "err when done low", int'(err_o), 1);

        // R9: zero byte count, then invalid mode
        bytes = {};
        run_load(1, 0, -1, 1'b1, 1'b0);
        check_val("R9", "err on zero count", int'(err_o), 1);
        bytes = '{8'h11, 8'h22};
        run_load(3, 0, -1, 1'b1, 1'b0);
        check_val("R9", "err on invalid mode", int'(err_o), 1);

        // R7: status drops after two of four bytes
        bytes = '{8'h01, 8'h02, 8'h03, 8'h04};
        run_load(1, 0, 2, 1'b1, 1'b0);
        check_val("R7", "sent at abort", int'(sent_o), 2);

        // R7: status low before the first byte
        bytes = '{8'hEE};
        run_load(0, 0, 0, 1'b1, 1'b0);
        check_val("R7", "sent at first-byte abort", int'(sent_o), 0);

        // R11: a start during the settle wait is ignored
        bytes = '{8'h96, 8'h69};
        run_load(2, 0, -1, 1'b1, 1'b1);
        check_val("R11", "ok despite busy start", int'(ok_o), 1);
        repeat (4) @(posedge clk);
        check_val("R11", "ok held in idle", int'(ok_o), 1);

        // R11: the next accepted start clears the flags
        bytes = '{8'h0F};
        run_load(1, 0, -1, 1'b1, 1'b0);
        check_val("R11", "ok after final load", int'(ok_o), 1);

        cmp_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule